// File: doc/BRIEF.md
# Byte-Wide Slave Configuration Loader

This block loads a target FPGA through its byte-wide slave parallel configuration port, using an image held in a word-wide flash. A one-cycle reload strobe, together with a flash start address, starts a load. The loader first drives an active-low program request to the target for a fixed number of system clocks. It then waits until the target's INIT line, after synchronization, reads high. Only then does it begin fetching image words from flash.

Flash reads have a latency of several cycles and return 16-bit words. The loader keeps at most one read in flight. It holds one word being serialized and one word fetched ahead. It splits each word into bytes, high byte first. It drives a configuration clock made from the system clock by a phase counter: two system clocks low, then two high. Each byte is placed on the data pins while the clock is low, so it has two system clocks of setup and two of hold around the rising edge. The loader stops when the target's DONE input reads high, or with an error when the byte budget is used up first.

Top module: `cfg_loader`

## Requirements
- R1: After reset, prog_n is 1, cclk is 0, rd_req is 0, and busy, load_ok and load_err are all 0.
- R2: A reconf_stb seen while idle captures start_addr, clears load_ok and load_err, and drives prog_n low for exactly PROG_CYC (4) system clocks, once per load.
- R3: No flash read is requested and no cclk rising edge occurs until tgt_init, passed through a two-flop synchronizer, has been seen high after the program pulse.
- R4: Flash reads use addresses start_addr, start_addr+1, start_addr+2, ... in order. rd_req is a one-cycle pulse, and a new read is issued only after the previous rd_valid.
- R5: Each 16-bit flash word is delivered as two bytes, bits [15:8] first and then bits [7:0], and words are delivered in address order.
- R6: cclk has a period of at least 4 system clocks and is exactly 4 when data keeps up: 2 clocks low, then 2 clocks high. cfg_data changes only while cclk is low, and it is stable in the cycle before each rising edge and throughout the high phase.
- R7: If the next byte has not yet arrived from flash, cclk stays low and no rising edge is produced until the byte is available. The byte order stays unchanged.
- R8: When the synchronized tgt_done reads high during a load, the loader returns to idle with cclk low, busy 0, load_ok 1 and load_err 0. It produces no further cclk rising edge.
- R9: A load never produces more than byte_limit cclk rising edges. If another edge would be needed and DONE has not been seen, the loader stops with load_err 1 and load_ok 0.
- R10: A reconf_stb seen while busy is ignored. The program pulse is not repeated and the byte stream continues from the original address.
- R11: busy is 1 from the cycle after an accepted strobe until the load ends through R8 or R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reconf_stb | input | 1 | One-cycle request to start a load |
| start_addr | input | ADDR_W | Flash word address of the image, captured with the strobe |
| byte_limit | input | CNT_W | Maximum number of bytes clocked into the target |
| prog_n | output | 1 | Active-low program request to the target |
| tgt_init | input | 1 | Target INIT status, asynchronous |
| tgt_done | input | 1 | Target DONE status, asynchronous |
| rd_req | output | 1 | One-cycle flash read request |
| rd_addr | output | ADDR_W | Flash word address, valid with rd_req |
| rd_valid | input | 1 | Flash read data valid strobe |
| rd_data | input | WORD_W | Flash read word |
| cclk | output | 1 | Divided configuration clock |
| cfg_data | output | 8 | Configuration byte |
| busy | output | 1 | Load in progress |
| load_ok | output | 1 | Last load ended with DONE |
| load_err | output | 1 | Last load ran out of byte budget |

## Verification
A wrong serializer or prefetch state shows up at the ports as a wrong or repeated byte at the very next cclk rising edge. It can also show up as a gap longer than four clocks, so every captured byte is compared against the flash model and every clock gap is measured. A wrong phase counter shows within one cclk period, as data changing while cclk is high or in the cycle before a rise. Errors in the sequencer's state show within a few cycles of the load ending, and the tests look for them in four places: the final cclk edge count, the flags, the read address sequence, and the count of program pulses, including during a long INIT hold and a strobe sent while busy.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_PULSE,
    SEQ_WAIT_INIT,
    SEQ_STREAM
  } seq_state_t;
endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cfgl_fetch.sv
module cfgl_fetch #(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              en,
  input  logic              pop,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  output logic              byte_avail,
  output logic [7:0]        byte_out
);
  localparam int BPW = WORD_W / 8;
  localparam int LW  = $clog2(BPW + 1);
  localparam logic [LW-1:0] FULL = LW'(BPW);

  logic [WORD_W-1:0] cur_w, cur_w_n, nxt_w, nxt_w_n;
  logic [LW-1:0]     cur_left, cur_left_n;
  logic              nxt_v, nxt_v_n;
  logic              outst, outst_n, issue;
  logic [ADDR_W-1:0] next_addr, addr_q;
  logic              req_q;

  assign byte_avail = (cur_left != '0);
  assign byte_out   = cur_w[WORD_W-1 -: 8];
  assign rd_req     = req_q;
  assign rd_addr    = addr_q;

  always_comb begin
    cur_w_n    = cur_w;
    cur_left_n = cur_left;
    nxt_w_n    = nxt_w;
    nxt_v_n    = nxt_v;
    if (pop) begin
      cur_w_n    = cur_w << 8;
      cur_left_n = cur_left - LW'(1);
    end
    if (cur_left_n == '0 && nxt_v_n) begin
      cur_w_n    = nxt_w;
      cur_left_n = FULL;
      nxt_v_n    = 1'b0;
    end
    if (rd_valid) begin
      if (cur_left_n == '0) begin
        cur_w_n    = rd_data;
        cur_left_n = FULL;
      end else begin
        nxt_w_n = rd_data;
        nxt_v_n = 1'b1;
      end
    end
    outst_n = outst & ~rd_valid;
    issue   = en && !outst_n && !nxt_v_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_w     <= '0;
      cur_left  <= '0;
      nxt_w     <= '0;
      nxt_v     <= 1'b0;
      outst     <= 1'b0;
      req_q     <= 1'b0;
      addr_q    <= '0;
      next_addr <= '0;
    end else if (clear) begin
      cur_left  <= '0;
      nxt_v     <= 1'b0;
      outst     <= 1'b0;
      req_q     <= 1'b0;
      next_addr <= base_addr;
    end else begin
      cur_w    <= cur_w_n;
      cur_left <= cur_left_n;
      nxt_w    <= nxt_w_n;
      nxt_v    <= nxt_v_n;
      outst    <= outst_n | issue;
      req_q    <= issue;
      if (issue) begin
        addr_q    <= next_addr;
        next_addr <= next_addr + ADDR_W'(1);
      end
    end
  end

  // R4: at most one read in flight, so requests never come back to back
  p_single_read_r4: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  // R5: a returning word always finds a free slot
  p_no_overrun_r5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !(nxt_v && cur_left != '0));

  // R7: the sequencer only consumes bytes that are present
  p_pop_avail_r7: assert property (@(posedge clk) disable iff (rst)
    pop |-> byte_avail);
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfgl_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int WORD_W      = 16,
  parameter int CNT_W       = 16,
  parameter int HALF_DIV    = 2,
  parameter int PROG_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reconf_stb,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_limit,
  output logic              prog_n,
  input  logic              tgt_init,
  input  logic              tgt_done,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  output logic              cclk,
  output logic [7:0]        cfg_data,
  output logic              busy,
  output logic              load_ok,
  output logic              load_err
);
  localparam int PH_N = 2 * HALF_DIV;
  localparam int PH_W = (PH_N > 1) ? $clog2(PH_N) : 1;
  localparam int PC_W = (PROG_CYC > 1) ? $clog2(PROG_CYC) : 1;
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF_DIV - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PH_N - 1);
  localparam logic [PC_W-1:0] PC_END  = PC_W'(PROG_CYC - 1);

  seq_state_t        state;
  logic [PC_W-1:0]   pcnt;
  logic [PH_W-1:0]   ph;
  logic              armed;
  logic [CNT_W-1:0]  sent_cnt;
  logic              prog_q, cclk_q, ok_q, err_q;
  logic [7:0]        data_q;
  logic [1:0]        sync_q;
  logic              init_s, done_s;
  logic              accept, fetch_en, pop_c, byte_avail;
  logic [7:0]        byte_out;

  cfgl_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({tgt_init, tgt_done}),
    .q   (sync_q)
  );
  assign init_s = sync_q[1];
  assign done_s = sync_q[0];

  assign accept   = (state == SEQ_IDLE) && reconf_stb;
  assign fetch_en = (state == SEQ_STREAM);
  assign pop_c    = (state == SEQ_STREAM) && !done_s && byte_avail &&
                    (!armed || ph == PH_LAST);

  cfgl_fetch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .clear      (accept),
    .base_addr  (start_addr),
    .en         (fetch_en),
    .pop        (pop_c),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .byte_avail (byte_avail),
    .byte_out   (byte_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      pcnt     <= '0;
      ph       <= '0;
      armed    <= 1'b0;
      sent_cnt <= '0;
      prog_q   <= 1'b1;
      cclk_q   <= 1'b0;
      data_q   <= '0;
      ok_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (reconf_stb) begin
            state    <= SEQ_PULSE;
            prog_q   <= 1'b0;
            pcnt     <= '0;
            ok_q     <= 1'b0;
            err_q    <= 1'b0;
            sent_cnt <= '0;
            armed    <= 1'b0;
            ph       <= '0;
          end
        end
        SEQ_PULSE: begin
          if (pcnt == PC_END) begin
            prog_q <= 1'b1;
            state  <= SEQ_WAIT_INIT;
          end else begin
            pcnt <= pcnt + PC_W'(1);
          end
        end
        SEQ_WAIT_INIT: begin
          if (init_s) state <= SEQ_STREAM;
        end
        SEQ_STREAM: begin
          if (done_s) begin
            state  <= SEQ_IDLE;
            cclk_q <= 1'b0;
            armed  <= 1'b0;
            ok_q   <= 1'b1;
          end else if (!armed) begin
            if (pop_c) begin
              data_q <= byte_out;
              armed  <= 1'b1;
              ph     <= '0;
            end
          end else if (ph == PH_RISE) begin
            if (sent_cnt == byte_limit) begin
              state <= SEQ_IDLE;
              armed <= 1'b0;
              err_q <= 1'b1;
            end else begin
              cclk_q   <= 1'b1;
              sent_cnt <= sent_cnt + CNT_W'(1);
              ph       <= ph + PH_W'(1);
            end
          end else if (ph == PH_LAST) begin
            cclk_q <= 1'b0;
            ph     <= '0;
            if (pop_c) data_q <= byte_out;
            else       armed  <= 1'b0;
          end else begin
            ph <= ph + PH_W'(1);
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign prog_n   = prog_q;
  assign cclk     = cclk_q;
  assign cfg_data = data_q;
  assign busy     = (state != SEQ_IDLE);
  assign load_ok  = ok_q;
  assign load_err = err_q;

  // R2: program request released before waiting on INIT or streaming
  p_prog_released_r2: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_WAIT_INIT || state == SEQ_STREAM) |-> prog_n);

  // R3: reads only follow a cycle spent streaming after INIT
  p_read_after_init_r3: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> ($past(state) == SEQ_STREAM));

  // R6: data held across the whole high phase
  p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cclk && $past(cclk)) |-> $stable(cfg_data));

  // R6: data was already present the cycle before a rising edge
  p_data_setup_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(cclk) |-> $stable(cfg_data));

  // R9: rising edges never exceed the budget
  p_limit_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(cclk) |-> (sent_cnt != '0 && sent_cnt <= byte_limit));

  // R8: outcome flags exclusive, clock parked low when idle
  p_flags_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(load_ok && load_err));
  p_idle_clk_low_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cclk);
endmodule

// File: tb/cfg_loader_test.sv
module cfg_loader_test;
  localparam int ADDR_W = 24;
  localparam int WORD_W = 16;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reconf_stb = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [CNT_W-1:0]  byte_limit = '0;
  logic prog_n;
  logic tgt_init = 1'b1;
  logic tgt_done = 1'b0;
  logic rd_req;
  logic [ADDR_W-1:0] rd_addr;
  logic rd_valid = 1'b0;
  logic [WORD_W-1:0] rd_data = '0;
  logic cclk;
  logic [7:0] cfg_data;
  logic busy, load_ok, load_err;

  always #5 clk = ~clk;

  cfg_loader #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .reconf_stb(reconf_stb), .start_addr(start_addr),
    .byte_limit(byte_limit), .prog_n(prog_n), .tgt_init(tgt_init),
    .tgt_done(tgt_done), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .cclk(cclk), .cfg_data(cfg_data),
    .busy(busy), .load_ok(load_ok), .load_err(load_err)
  );

  int checks = 0;
  int failures = 0;

  int lat = 3;
  int init_dly = 5;
  int cyc = 0;
  int rises, gap_min, gap_max, last_rise, first_rise, init_rise;
  int stable_err, setup_err, prog_pulses, prog_len, prog_last, nrd, early_rd, icnt, cd;
  logic [7:0] cap [512];
  logic [ADDR_W-1:0] alog [512];
  logic [ADDR_W-1:0] pend_addr;
  logic prev_cclk = 1'b0, prev_prog = 1'b1;
  logic [7:0] prev_data = '0;

  function automatic logic [15:0] fw(input logic [ADDR_W-1:0] a);
    logic [15:0] t;
    t = a[15:0] * 16'd15133 + {a[23:16], 8'h00};
    return t ^ 16'hC35A;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [ADDR_W-1:0] s, input int k);
    logic [15:0] w;
    w = fw(s + ADDR_W'(k / 2));
    return (k % 2 == 0) ? w[15:8] : w[7:0];
  endfunction

  task automatic chk(input bit good, input string req, input longint act, input longint exp);
    checks++;
    if (!good) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    rises = 0; gap_min = 1000000; gap_max = 0; last_rise = 0; first_rise = 0;
    init_rise = 0; stable_err = 0; setup_err = 0; prog_pulses = 0;
    nrd = 0; early_rd = 0;
  endtask

  // monitor, target model and flash model, all at the falling clock edge
  initial begin
    cd = 0; icnt = 0; prog_len = 0; prog_last = 0;
    clear_logs();
    forever begin
      @(negedge clk);
      cyc++;
      if (cclk && !prev_cclk) begin
        if (cfg_data != prev_data) setup_err++;
        if (rises < 512) cap[rises] = cfg_data;
        if (rises > 0) begin
          if (cyc - last_rise < gap_min) gap_min = cyc - last_rise;
          if (cyc - last_rise > gap_max) gap_max = cyc - last_rise;
        end else first_rise = cyc;
        last_rise = cyc;
        rises++;
      end
      if (cclk && prev_cclk && cfg_data != prev_data) stable_err++;
      if (!prog_n) prog_len++;
      if (!prog_n && prev_prog) prog_pulses++;
      if (prog_n && !prev_prog) begin prog_last = prog_len; prog_len = 0; end
      if (rd_req) begin
        if (nrd < 512) alog[nrd] = rd_addr;
        nrd++;
        if (!tgt_init) early_rd++;
      end
      if (!prog_n) begin tgt_init = 1'b0; icnt = 0; end
      else if (!tgt_init) begin
        if (icnt >= init_dly) begin tgt_init = 1'b1; init_rise = cyc; end
        else icnt++;
      end
      rd_valid = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin rd_valid = 1'b1; rd_data = fw(pend_addr); end
      end
      if (rd_req) begin cd = lat; pend_addr = rd_addr; end
      prev_cclk = cclk; prev_prog = prog_n; prev_data = cfg_data;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // one load; ndone = 0 means DONE never rises
  task automatic run_load(input logic [ADDR_W-1:0] s, input int ndone, input int limit,
                          input int l, input int idly, input int stb2_at,
                          input logic [ADDR_W-1:0] s2);
    int n;
    lat = l; init_dly = idly; tgt_done = 1'b0;
    clear_logs();
    @(negedge clk);
    start_addr = s; byte_limit = CNT_W'(limit); reconf_stb = 1'b1;
    @(negedge clk);
    reconf_stb = 1'b0;
    chk(busy == 1'b1, "R11 busy after strobe", busy, 1);
    chk(!load_ok && !load_err, "R2 flags cleared", {load_ok, load_err}, 0);
    n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
      if (stb2_at != 0 && n == stb2_at) begin start_addr = s2; reconf_stb = 1'b1; end
      else reconf_stb = 1'b0;
      if (ndone != 0 && rises >= ndone) tgt_done = 1'b1;
    end
    reconf_stb = 1'b0;
    start_addr = s;
    repeat (6) @(negedge clk);
  endtask

  task automatic check_stream(input logic [ADDR_W-1:0] s, input int nexp, input string tag);
    int bad;
    int abad;
    bad = 0; abad = 0;
    chk(rises == nexp, {tag, " R8 R9 rising edge count"}, rises, nexp);
    for (int i = 0; i < rises && i < 512; i++)
      if (cap[i] != exp_byte(s, i)) bad++;
    chk(bad == 0, {tag, " R5 byte order/content mismatches"}, bad, 0);
    for (int i = 0; i < nrd && i < 512; i++)
      if (alog[i] != s + ADDR_W'(i)) abad++;
    chk(abad == 0 && nrd >= (nexp + 1) / 2, {tag, " R4 read addresses"}, abad, 0);
    chk(stable_err == 0 && setup_err == 0, {tag, " R6 data stability"}, stable_err + setup_err, 0);
    chk(rises < 2 || gap_min >= 4, {tag, " R6 min cclk period"}, gap_min, 4);
    chk(prog_pulses == 1 && prog_last == 4, {tag, " R2 program pulse"}, prog_last, 4);
    chk(early_rd == 0 && (rises == 0 || first_rise > init_rise), {tag, " R3 init gating"}, early_rd, 0);
    chk(!cclk && !busy, {tag, " R8 idle after load"}, {cclk, busy}, 0);
  endtask

  task automatic t_reset();
    chk(prog_n == 1'b1 && cclk == 1'b0 && rd_req == 1'b0, "R1 reset pins",
        {prog_n, cclk, rd_req}, 3'b100);
    chk(!busy && !load_ok && !load_err, "R1 reset flags", {busy, load_ok, load_err}, 0);
  endtask

  task automatic t_basic();
    run_load(24'h000100, 10, 100, 3, 5, 0, '0);
    check_stream(24'h000100, 10, "basic");
    chk(gap_max == 4, "basic R6 steady period", gap_max, 4);
    chk(load_ok && !load_err, "basic R8 ok flag", {load_ok, load_err}, 2'b10);
  endtask

  task automatic t_odd();
    run_load(24'h12ABFE, 7, 100, 2, 3, 0, '0);
    check_stream(24'h12ABFE, 7, "odd");
    chk(load_ok, "odd R8 ok flag", load_ok, 1);
  endtask

  task automatic t_limit();
    run_load(24'h000040, 0, 6, 3, 5, 0, '0);
    check_stream(24'h000040, 6, "limit");
    chk(load_err && !load_ok, "limit R9 error flag", {load_ok, load_err}, 2'b01);
  endtask

  task automatic t_after_err();
    run_load(24'h000200, 4, 50, 3, 5, 0, '0);
    check_stream(24'h000200, 4, "reload");
    chk(load_ok && !load_err, "reload R2 error cleared", {load_ok, load_err}, 2'b10);
  endtask

  task automatic t_stall();
    run_load(24'h000300, 6, 50, 12, 5, 0, '0);
    check_stream(24'h000300, 6, "stall");
    chk(gap_max > 4, "stall R7 clock paused", gap_max, 5);
  endtask

  task automatic t_busy_ignore();
    run_load(24'h000500, 12, 100, 3, 5, 30, 24'h00F000);
    check_stream(24'h000500, 12, "busy R10");
    chk(load_ok, "busy R10 completion", load_ok, 1);
  endtask

  task automatic t_init_hold();
    run_load(24'h000700, 5, 100, 3, 60, 0, '0);
    check_stream(24'h000700, 5, "inithold R3");
    chk(first_rise > init_rise && init_rise - first_rise < 0, "inithold R3 first edge after INIT",
        first_rise, init_rise);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_odd();
    t_limit();
    t_after_err();
    t_stall();
    t_busy_ignore();
    t_init_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule